// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Output

This block is an 18-bit first-in first-out buffer whose write side and read side each run from their own clock. The two clocks may be the same net or fully unrelated. Storage depth is a parameter from 256 to 4096 words. Pointers cross between the domains in Gray code through two-stage synchronizers. The full condition and the half-full count are formed in the write domain. The empty condition is formed in the read domain.

Two output timing modes share one core, and the `ft_mode` input selects between them. It is sampled on clock edges while reset is held low, so both clocks must run during reset.

- **Standard mode:** every word must be fetched with an explicit read. `out_flag` means "empty" and `in_flag` means "full".
- **Fall-through mode:** the head word moves into the output register on its own. `out_flag` means "output ready" and `in_flag` means "input ready".

Top module: `dualclk_fifo`

## Requirements
- R1: While `rst_n` is low, the mode is taken from `ft_mode` (0 = standard, 1 = fall-through), both pointers clear and `rd_data` is 0. Right after reset:
  - `half_full` is 0.
  - In standard mode `out_flag`=1 and `in_flag`=0.
  - In fall-through mode `out_flag`=0 and `in_flag`=1.
- R2: On each rising `wclk` edge with `wr_en`=1 while the buffer is not full, `wr_data` is stored and the write pointer advances by one. Words leave in the order they were written.
- R3: In standard mode, a stored word reaches `rd_data` only through a read: a rising `rclk` edge with `rd_en`=1 while not empty. That edge loads the next word. Without a read, `rd_data` holds its value.
- R4: A read while empty has no effect. In standard mode `rd_data` keeps its value and the read pointer does not move. In fall-through mode `rd_en` while `out_flag`=0 changes nothing.
- R5: In fall-through mode, a word written into an empty buffer appears on `rd_data`, with `out_flag`=1, on the third `rclk` edge after the `wclk` edge that stored it. This happens without `rd_en`, and it applies when both clocks are tied.
- R6: In fall-through mode, an `rclk` edge with `rd_en`=1 and `out_flag`=1 consumes the shown word.
  - If another word is stored, it replaces the shown word on that same edge.
  - Otherwise `out_flag` drops to 0.
  - Without `rd_en`, the shown word and `out_flag` hold.
- R7: In standard mode, `out_flag` is 1 exactly when the read domain sees no stored word. After a write into an empty buffer, it falls on the second `rclk` edge after the write edge, with clocks tied.
- R8: When storage holds DEPTH words, standard mode sets `in_flag`=1 and fall-through mode sets `in_flag`=0. The output register in fall-through mode can hold one word more than storage. Writes while full are dropped.
- R9: `half_full` is 1 when the write domain counts more than DEPTH/2 words in storage, and 0 otherwise.
- R10: Data passes intact, in order and with no loss, in both modes when `wclk` and `rclk` are unrelated and both sides stall in irregular patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock (may be tied to wclk) |
| rst_n | input | 1 | Asynchronous active-low reset; both clocks must run while it is low |
| ft_mode | input | 1 | Mode select sampled during reset: 0 standard, 1 fall-through |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | 18 | Registered read data |
| out_flag | output | 1 | Empty (standard mode) or output ready (fall-through mode) |
| in_flag | output | 1 | Full (standard mode) or input ready (fall-through mode) |
| half_full | output | 1 | More than DEPTH/2 words in storage |

## Verification
The hardest state to reach from the ports is the full condition in fall-through mode. It needs DEPTH+1 words outstanding, because the output register holds one word beyond storage, and the read pointer's single advance has to be synchronized back before the last write. The bench ties the clocks so that every synchronizer delay is an exact count. It then writes DEPTH+1 words with no reads, and checks the ready flag, a dropped extra write, and an ordered drain. Exact three-edge fall-through timing and exact half-full thresholds use the same tied clocks. Unrelated clocks are covered by a stalling producer and consumer running against a queue model.

// File: rtl/dualclk_fifo.sv
module dualclk_fifo #(
  parameter int DW    = 18,
  parameter int DEPTH = 256
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          ft_mode,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          out_flag,
  output logic          in_flag,
  output logic          half_full
);
  localparam int AW = $clog2(DEPTH);

  function automatic logic [AW:0] to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] to_bin(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wbin, wgray, rq1, rq2;
  logic [AW:0]   rbin, rgray, wq1, wq2;
  logic          wmode, rmode, ovalid;
  logic          full, empty, wr_go, rd_go;
  logic [AW:0]   wfill;

  // write domain
  always_ff @(posedge wclk)
    if (!rst_n) wmode <= ft_mode;

  assign full  = wgray == {~rq2[AW:AW-1], rq2[AW-2:0]};
  assign wr_go = wr_en && !full;
  assign wfill = wbin - to_bin(rq2);

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rq1   <= '0;
      rq2   <= '0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (wr_go) begin
        wbin  <= wbin + 1'b1;
        wgray <= to_gray(wbin + 1'b1);
      end
    end

  always_ff @(posedge wclk)
    if (wr_go) mem[wbin[AW-1:0]] <= wr_data;

  assign in_flag   = wmode ? !full : full;
  assign half_full = wfill > (AW+1)'(DEPTH / 2);

  // read domain
  always_ff @(posedge rclk)
    if (!rst_n) rmode <= ft_mode;

  assign empty = rgray == wq2;
  assign rd_go = rmode ? (!empty && (!ovalid || rd_en)) : (rd_en && !empty);

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      wq1     <= '0;
      wq2     <= '0;
      ovalid  <= 1'b0;
      rd_data <= '0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
      if (rd_go) begin
        rbin    <= rbin + 1'b1;
        rgray   <= to_gray(rbin + 1'b1);
        rd_data <= mem[rbin[AW-1:0]];
        ovalid  <= 1'b1;
      end else if (rd_en) begin
        ovalid  <= 1'b0;
      end
    end

  assign out_flag = rmode ? ovalid : empty;
endmodule

// File: rtl/dualclk_fifo_chk.sv
module dualclk_fifo_chk #(
  parameter int AW = 8,
  parameter int DW = 18
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          full,
  input logic          empty,
  input logic          half_full,
  input logic          rmode,
  input logic          out_flag,
  input logic [AW:0]   wbin,
  input logic [AW:0]   rbin,
  input logic [DW-1:0] rd_data
);
  assert_no_overflow_R8: assert property (@(posedge wclk) disable iff (!rst_n)
    full |=> wbin == $past(wbin));

  assert_wptr_step_R2: assert property (@(posedge wclk) disable iff (!rst_n)
    (wbin == $past(wbin)) || (wbin == (AW+1)'($past(wbin) + 1'b1)));

  assert_full_half_R9: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> half_full);

  assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    empty |=> rbin == $past(rbin));

  assert_std_hold_R3: assert property (@(posedge rclk) disable iff (!rst_n)
    (!rmode && !rd_en) |=> $stable(rd_data));

  assert_ft_hold_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    (rmode && out_flag && !rd_en) |=> (out_flag && $stable(rd_data)));
endmodule

bind dualclk_fifo dualclk_fifo_chk #(.AW(AW), .DW(DW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .rd_en(rd_en),
  .full(full), .empty(empty), .half_full(half_full), .rmode(rmode),
  .out_flag(out_flag), .wbin(wbin), .rbin(rbin), .rd_data(rd_data)
);

// File: tb/dualclk_fifo_test.sv
module dualclk_fifo_test;
  localparam int DEPTH = 256;

  logic wclk = 0, rclk_free = 0, tie = 1;
  logic rclk;
  logic rst_n = 0, ft_mode = 0, wr_en = 0, rd_en = 0;
  logic [17:0] wr_data = '0;
  logic [17:0] rd_data;
  logic out_flag, in_flag, half_full;
  int checks = 0, fails = 0;

  always #4 wclk = ~wclk;
  always #6.5 rclk_free = ~rclk_free;
  assign rclk = tie ? wclk : rclk_free;

  dualclk_fifo #(.DW(18), .DEPTH(DEPTH)) uut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .ft_mode(ft_mode),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .out_flag(out_flag), .in_flag(in_flag), .half_full(half_full));

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wtick();
    @(posedge wclk);
    @(negedge wclk);
  endtask

  task automatic reset_dut(input logic m, input logic t);
    @(negedge wclk);
    tie = t; ft_mode = m; rst_n = 0; wr_en = 0; rd_en = 0;
    repeat (6) wtick();
    rst_n = 1;
    wtick();
  endtask

  task automatic push(input logic [17:0] d);
    wr_en = 1; wr_data = d;
    wtick();
    wr_en = 0;
  endtask

  task automatic t_reset_std();
    reset_dut(0, 1);
    chk("R1 std out_flag", 18'(out_flag), 18'd1);
    chk("R1 std in_flag", 18'(in_flag), 18'd0);
    chk("R1 half_full", 18'(half_full), 18'd0);
    chk("R1 rd_data", rd_data, 18'd0);
  endtask

  task automatic t_std_latency();
    push(18'h1A5A5);
    chk("R7 empty after write edge", 18'(out_flag), 18'd1);
    wtick();
    chk("R7 empty after 1 edge", 18'(out_flag), 18'd1);
    wtick();
    chk("R7 not empty after 2 edges", 18'(out_flag), 18'd0);
    chk("R3 no fall-through", rd_data, 18'd0);
    rd_en = 1; wtick(); rd_en = 0;
    chk("R3 read data", rd_data, 18'h1A5A5);
    chk("R7 empty after read", 18'(out_flag), 18'd1);
  endtask

  task automatic t_std_empty_read();
    rd_en = 1;
    for (int i = 0; i < 3; i++) begin
      wtick();
      chk("R4 hold on empty read", rd_data, 18'h1A5A5);
    end
    rd_en = 0;
    push(18'h00B0B);
    repeat (3) wtick();
    chk("R3 held without read", rd_data, 18'h1A5A5);
    rd_en = 1; wtick(); rd_en = 0;
    chk("R4 pointer unmoved", rd_data, 18'h00B0B);
  endtask

  task automatic t_std_full();
    reset_dut(0, 1);
    for (int i = 0; i < DEPTH / 2; i++) push(18'(i));
    chk("R9 at half", 18'(half_full), 18'd0);
    push(18'(DEPTH / 2));
    chk("R9 above half", 18'(half_full), 18'd1);
    chk("R8 not full yet", 18'(in_flag), 18'd0);
    for (int i = DEPTH / 2 + 1; i < DEPTH; i++) push(18'(i));
    chk("R8 full", 18'(in_flag), 18'd1);
    push(18'h3FFFF);
    chk("R8 still full", 18'(in_flag), 18'd1);
    repeat (2) wtick();
    for (int i = 0; i < DEPTH; i++) begin
      rd_en = 1; wtick(); rd_en = 0;
      chk("R2 std order", rd_data, 18'(i));
    end
    chk("R7 drained", 18'(out_flag), 18'd1);
    rd_en = 1; wtick(); rd_en = 0;
    chk("R8 dropped write absent", rd_data, 18'(DEPTH - 1));
    repeat (2) wtick();
    chk("R8 full released", 18'(in_flag), 18'd0);
    chk("R9 released", 18'(half_full), 18'd0);
  endtask

  task automatic t_ft_latency();
    reset_dut(1, 1);
    chk("R1 ft out_flag", 18'(out_flag), 18'd0);
    chk("R1 ft in_flag", 18'(in_flag), 18'd1);
    push(18'h2C3C3);
    chk("R5 edge0", 18'(out_flag), 18'd0);
    wtick();
    chk("R5 edge1", 18'(out_flag), 18'd0);
    wtick();
    chk("R5 edge2", 18'(out_flag), 18'd0);
    wtick();
    chk("R5 ready edge3", 18'(out_flag), 18'd1);
    chk("R5 data edge3", rd_data, 18'h2C3C3);
  endtask

  task automatic t_ft_reads();
    push(18'h0000B);
    push(18'h0000C);
    repeat (3) wtick();
    chk("R6 head held", rd_data, 18'h2C3C3);
    chk("R6 ready held", 18'(out_flag), 18'd1);
    rd_en = 1;
    wtick();
    chk("R6 next word", rd_data, 18'h0000B);
    wtick();
    chk("R6 third word", rd_data, 18'h0000C);
    wtick();
    chk("R6 drained", 18'(out_flag), 18'd0);
    repeat (2) wtick();
    chk("R4 ft not ready read", 18'(out_flag), 18'd0);
    rd_en = 0;
    push(18'h0000D);
    repeat (3) wtick();
    chk("R4 ft nothing skipped", rd_data, 18'h0000D);
    chk("R5 ready again", 18'(out_flag), 18'd1);
  endtask

  task automatic t_ft_full();
    reset_dut(1, 1);
    for (int i = 0; i < DEPTH; i++) push(18'(i));
    chk("R8 ft room for one more", 18'(in_flag), 18'd1);
    push(18'(DEPTH));
    chk("R8 ft input not ready", 18'(in_flag), 18'd0);
    push(18'h3FFFF);
    chk("R8 ft still not ready", 18'(in_flag), 18'd0);
    rd_en = 1;
    for (int i = 0; i <= DEPTH; i++) begin
      chk("R6 ft order", rd_data, 18'(i));
      wtick();
    end
    rd_en = 0;
    chk("R8 ft dropped write absent", 18'(out_flag), 18'd0);
    repeat (2) wtick();
    chk("R8 ft input ready again", 18'(in_flag), 18'd1);
  endtask

  task automatic t_async(input logic m);
    logic [17:0] q[$];
    int sent = 0, got = 0;
    reset_dut(m, 0);
    fork
      begin
        while (sent < 300) begin
          @(negedge wclk);
          wr_en = 0;
          if (($urandom % 4 != 0) && (m ? in_flag : !in_flag)) begin
            wr_en = 1;
            wr_data = 18'($urandom);
            q.push_back(wr_data);
            sent++;
          end
        end
        @(negedge wclk);
        wr_en = 0;
      end
      begin
        logic pend = 0;
        while (got < 300) begin
          @(negedge rclk);
          rd_en = 0;
          if (pend) begin
            chk("R10 std async data", rd_data, q.pop_front());
            got++;
            pend = 0;
          end
          if (got < 300 && ($urandom % 3 != 0) && (m ? out_flag : !out_flag)) begin
            rd_en = 1;
            if (m) begin
              chk("R10 ft async data", rd_data, q.pop_front());
              got++;
            end else pend = 1;
          end
        end
        @(negedge rclk);
        rd_en = 0;
      end
    join
    repeat (4) @(negedge rclk);
    chk("R10 async drained", 18'(out_flag), m ? 18'd0 : 18'd1);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset_std();
    t_std_latency();
    t_std_empty_read();
    t_std_full();
    t_ft_latency();
    t_ft_reads();
    t_ft_full();
    t_async(0);
    t_async(1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule